// File: doc/BRIEF.md
# Dual Timer with Shared Toggle Output

This block holds two down-counting timers. Each timer is a prescaler that feeds an 8-bit counter, and each has its own reload values. When a timer reaches its end of count it sends out a one-cycle interrupt request pulse, reloads itself and keeps counting. A two-bit select field in the mode register decides which timer, if either, drives a single shared output pin. The selected timer drives the pin through a toggle flip-flop, so the pin inverts on every end of count of that timer. When no timer is selected, the pin carries an ordinary port data bit.

Software programs the block through a simple write port. One write to the mode register can do four things together: pick the timer, preset the pin high, reload the timer and start it. After a mode write that sets the load and run bits, the timer's first decrement happens on the following clock. The timer then repeats at a fixed period of prescale × count cycles, so the pin's square wave has a period of twice that.

Top module: `twin_timer_pin`

## Requirements
- R1: After reset both interrupt outputs are low, no timer runs, the select field is 00, the port data bit is 0 and so the pin is 0. The toggle flip-flop resets to 1.
- R2: Write addresses: 0 is the mode register, 1 is the T0 count reload, 2 is the T0 prescale reload (low 6 bits), 3 is the T1 count reload, 4 is the T1 prescale reload, and 5 is the port data register (bit 0). A prescale reload of 0 means 64 and a count reload of 0 means 256.
- R3: Mode register bits: bit 0 loads T0, bit 1 lets T0 run, bit 2 loads T1, bit 3 lets T1 run, and bits [7:6] are the pin select. Load bits are strobes that are not stored. A later mode write without a load bit does not restart a running timer.
- R4: Select 01 routes T0's toggle flop to the pin and 10 routes T1's. With 00 or 11 the pin follows the port data bit, even while timers are running.
- R5: A mode write that sets the load bit of the timer named by the select field in that same write drives the pin to 1 on the clock edge that takes the write.
- R6: When a mode write with load and run set is taken at edge k, the first interrupt of that timer rises at edge k + P×C, where P and C are the effective prescale and count. Each interrupt is a single-cycle pulse whenever P×C > 1.
- R7: A running timer raises its interrupt every P×C cycles. While it is selected, the pin inverts on each of those edges, which gives a pin period of 2×P×C.
- R8: A timer whose run bit is 0 holds its state and raises no interrupt, even after a load.
- R9: An end of count of the timer that is not selected does not change the pin.
- R10: Changing the select field between 01 and 10 without a load bit keeps the toggle flip-flop's current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| irq0 | output | 1 | T0 end-of-count pulse |
| irq1 | output | 1 | T1 end-of-count pulse |
| pinOut | output | 1 | Shared output pin |

## Verification
The hardest case to reach from the ports is a mode write that lands while a timer is in the middle of counting. The write must either leave the count alone (no load bit) or switch the pin source without disturbing the toggle value. The bench starts a timer and waits a known number of edges. It then issues the mid-count write and measures the remaining cycles to the next interrupt, which must match a count computed from the original start. Random prescale and count values are mixed with the wrap-around reload values 0 (64 and 256) to measure the periods at their extremes.

// File: rtl/ttp_pkg.sv
package ttp_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 8;
  localparam int PRE_W     = 6;
  localparam int NUM_TMR   = 2;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 3'd5;

  localparam logic [1:0] SEL_T0 = 2'b01;
  localparam logic [1:0] SEL_T1 = 2'b10;

  typedef struct packed {
    logic [NUM_TMR-1:0] load;
    logic [NUM_TMR-1:0] run;
    logic [1:0]         sel;
    logic               preset;
    logic               portBit;
  } ctlStrobe_t;
endpackage

// File: rtl/ttp_ctrl.sv
module ttp_ctrl
  import ttp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [AW-1:0]             wrAddr,
  input  logic [DW-1:0]             wrData,
  output ctlStrobe_t                ctl,
  output logic [NUM_TMR-1:0][CW-1:0] cntReload,
  output logic [NUM_TMR-1:0][PW-1:0] preReload
);
  localparam int SEL_LO = DW - 2;

  logic                 modeWr;
  logic [NUM_TMR-1:0]   loadS;
  logic [NUM_TMR-1:0]   runQ;
  logic [1:0]           selQ;
  logic [1:0]           selNew;
  logic                 portQ;

  assign modeWr = wrEn && (wrAddr == ADDR_MODE);
  assign selNew = wrData[SEL_LO +: 2];

  generate
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmrRegs
      localparam logic [AW-1:0] CNT_ADDR = AW'(1 + 2*t);
      localparam logic [AW-1:0] PRE_ADDR = AW'(2 + 2*t);

      assign loadS[t] = modeWr && wrData[2*t];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          runQ[t]      <= 1'b0;
          cntReload[t] <= '0;
          preReload[t] <= '0;
        end else if (wrEn) begin
          if (wrAddr == ADDR_MODE) runQ[t]      <= wrData[2*t+1];
          if (wrAddr == CNT_ADDR)  cntReload[t] <= wrData[CW-1:0];
          if (wrAddr == PRE_ADDR)  preReload[t] <= wrData[PW-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= 2'b00;
      portQ <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_MODE) selQ  <= selNew;
      if (wrAddr == ADDR_PORT) portQ <= wrData[0];
    end
  end

  always_comb begin
    ctl.load    = loadS;
    ctl.run     = runQ;
    ctl.sel     = selQ;
    ctl.portBit = portQ;
    ctl.preset  = ((selNew == SEL_T0) && loadS[0]) ||
                  ((selNew == SEL_T1) && loadS[1]);
  end
endmodule

// File: rtl/ttp_timer.sv
module ttp_timer #(
  parameter int CW = 8,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] cntReload,
  input  logic [PW-1:0] preReload,
  output logic          eocNow,
  output logic          irq
);
  logic [PW-1:0] preCnt;
  logic [CW-1:0] cnt;
  logic          preExpire;
  logic          active;

  assign active    = run && !load;
  assign preExpire = (preCnt == PW'(1));
  assign eocNow    = active && preExpire && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= eocNow;
      if (load) begin
        preCnt <= preReload;
        cnt    <= cntReload;
      end else if (run) begin
        if (preExpire) begin
          preCnt <= preReload;
          if (cnt == CW'(1)) cnt <= cntReload;
          else               cnt <= cnt - CW'(1);
        end else begin
          preCnt <= preCnt - PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ttp_dpath.sv
module ttp_dpath
  import ttp_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 ctl,
  input  logic [NUM_TMR-1:0][CW-1:0] cntReload,
  input  logic [NUM_TMR-1:0][PW-1:0] preReload,
  output logic [NUM_TMR-1:0]         irq,
  output logic                       pinOut
);
  logic [NUM_TMR-1:0] eocNow;
  logic               togQ;
  logic               selEoc;

  generate
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      ttp_timer #(.CW(CW), .PW(PW)) u_tmr (
        .clk       (clk),
        .rstN      (rstN),
        .load      (ctl.load[t]),
        .run       (ctl.run[t]),
        .cntReload (cntReload[t]),
        .preReload (preReload[t]),
        .eocNow    (eocNow[t]),
        .irq       (irq[t])
      );
    end
  endgenerate

  always_comb begin
    case (ctl.sel)
      SEL_T0:  selEoc = eocNow[0];
      SEL_T1:  selEoc = eocNow[1];
      default: selEoc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           togQ <= 1'b1;
    else if (ctl.preset) togQ <= 1'b1;
    else if (selEoc)     togQ <= ~togQ;
  end

  assign pinOut = ((ctl.sel == SEL_T0) || (ctl.sel == SEL_T1)) ? togQ : ctl.portBit;
endmodule

// File: rtl/twin_timer_pin.sv
module twin_timer_pin
  import ttp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              irq0,
  output logic              irq1,
  output logic              pinOut
);
  ctlStrobe_t                    ctl;
  logic [NUM_TMR-1:0][CNT_W-1:0] cntReload;
  logic [NUM_TMR-1:0][PRE_W-1:0] preReload;
  logic [NUM_TMR-1:0]            irqVec;

  ttp_ctrl #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W), .PW(PRE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .ctl       (ctl),
    .cntReload (cntReload),
    .preReload (preReload)
  );

  ttp_dpath #(.CW(CNT_W), .PW(PRE_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cntReload (cntReload),
    .preReload (preReload),
    .irq       (irqVec),
    .pinOut    (pinOut)
  );

  assign irq0 = irqVec[0];
  assign irq1 = irqVec[1];
endmodule

// File: rtl/ttp_checker.sv
module ttp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic [7:0] wrData,
  input logic       irq0,
  input logic       irq1,
  input logic       pinOut,
  input logic [1:0] selQ,
  input logic [1:0] runQ,
  input logic       portBit
);
  logic modeWr;
  assign modeWr = wrEn && (wrAddr == 3'd0);

  AST_PORT_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && wrData[7:6] == 2'b00) |=> (pinOut == portBit)); // R4

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && ((wrData[7:6] == 2'b01 && wrData[0]) || (wrData[7:6] == 2'b10 && wrData[2])))
    |=> pinOut); // R5

  AST_NO_IRQ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && wrData[0]) |=> !irq0); // R6

  AST_T0_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (irq0 && selQ == 2'b01 && $past(selQ) == 2'b01) |-> (pinOut != $past(pinOut))); // R7

  AST_T1_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (irq1 && selQ == 2'b10 && $past(selQ) == 2'b10) |-> (pinOut != $past(pinOut))); // R7

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (irq0 || irq1) |-> ((irq0 && $past(runQ[0])) || (irq1 && $past(runQ[1])))); // R8

  AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq1 && !irq0 && selQ == 2'b01 && $past(selQ) == 2'b01 && !$past(wrEn))
    |-> $stable(pinOut)); // R9

  AST_SEL_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && !wrData[0] && !wrData[2] && (selQ == 2'b01 || selQ == 2'b10) &&
     (wrData[7:6] == 2'b01 || wrData[7:6] == 2'b10))
    |=> (irq0 || irq1 || $stable(pinOut))); // R10
endmodule

bind twin_timer_pin ttp_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .irq0    (irq0),
  .irq1    (irq1),
  .pinOut  (pinOut),
  .selQ    (ctl.sel),
  .runQ    (ctl.run),
  .portBit (ctl.portBit)
);

// File: tb/sim_twin_timer_pin.sv
`timescale 1ns/1ps
module sim_twin_timer_pin;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       irq0, irq1, pinOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  twin_timer_pin u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .irq0(irq0), .irq1(irq1), .pinOut(pinOut)
  );

  function automatic int effPeriod(input int p, input int c);
    return (p == 0 ? 64 : p) * (c == 0 ? 256 : c);
  endfunction

  function automatic logic [7:0] modeByte(input int sel, input bit ld0, input bit rn0,
                                          input bit ld1, input bit rn1);
    return {sel[1:0], 2'b00, rn1, ld1, rn0, ld0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr[2:0]; wrData = data[7:0];
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitIrq(input int t, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!(t == 0 ? irq0 : irq1) && n < 20000);
  endtask

  task automatic setTimer(input int t, input int p, input int c);
    wr(1 + 2*t, c);
    wr(2 + 2*t, p);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int n, p, c, t, per, cnt;
    logic held;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(pinOut == 1'b0, "R1 pin", pinOut, 0);
    chk(irq0 == 1'b0 && irq1 == 1'b0, "R1 irq", {irq1, irq0}, 0);

    // R4: port fallback with select 00 and 11
    wr(5, 1); chk(pinOut == 1'b1, "R4 port=1", pinOut, 1);
    wr(5, 0); chk(pinOut == 1'b0, "R4 port=0", pinOut, 0);
    wr(0, modeByte(3, 0, 0, 0, 0)); wr(5, 1);
    chk(pinOut == 1'b1, "R4 sel11", pinOut, 1);

    // R5/R6/R7 random periods on both timers
    for (int i = 0; i < 8; i++) begin
      t = $urandom % 2; p = 1 + $urandom % 7; c = 1 + $urandom % 9;
      per = effPeriod(p, c);
      setTimer(t, p, c);
      wr(0, t == 0 ? modeByte(1, 1, 1, 0, 0) : modeByte(2, 0, 0, 1, 1));
      chk(pinOut == 1'b1, "R5 preset", pinOut, 1);
      waitIrq(t, n);
      chk(n == per, "R6 first eoc", n, per);
      chk(pinOut == 1'b0, "R7 toggle low", pinOut, 0);
      if (per > 1) begin
        @(posedge clk); #1;
        chk((t == 0 ? irq0 : irq1) == 1'b0, "R6 pulse width", 1, 0);
        waitIrq(t, n); n++;
      end else waitIrq(t, n);
      chk(n == per, "R7 period", n, per);
      chk(pinOut == 1'b1, "R7 toggle high", pinOut, 1);
    end

    // R2: wrap-around reload values
    setTimer(0, 0, 1);
    wr(0, modeByte(1, 1, 1, 0, 0)); waitIrq(0, n);
    chk(n == 64, "R2 prescale 0", n, 64);
    setTimer(1, 1, 0);
    wr(0, modeByte(2, 0, 0, 1, 1)); waitIrq(1, n);
    chk(n == 256, "R2 count 0", n, 256);
    setTimer(0, 0, 0);
    wr(0, modeByte(1, 1, 1, 0, 0)); waitIrq(0, n);
    chk(n == 16384, "R2 both 0", n, 16384);

    // R8: load without run
    setTimer(0, 1, 2);
    wr(0, modeByte(1, 1, 0, 0, 0));
    chk(pinOut == 1'b1, "R8 preset", pinOut, 1);
    cnt = 0;
    for (int k = 0; k < 60; k++) begin @(posedge clk); #1; if (irq0) cnt++; end
    chk(cnt == 0, "R8 no irq", cnt, 0);
    chk(pinOut == 1'b1, "R8 pin held", pinOut, 1);

    // R3: mode rewrite without load does not restart
    setTimer(0, 2, 5);
    wr(0, modeByte(1, 1, 1, 0, 0));
    repeat (4) @(posedge clk); #1;
    wr(0, modeByte(1, 0, 1, 0, 0));
    waitIrq(0, n);
    chk(n == 5, "R3 no restart", n, 5);

    // R9: unselected timer does not move pin
    wr(0, modeByte(1, 0, 0, 0, 0));
    setTimer(1, 1, 3);
    held = pinOut;
    wr(0, modeByte(1, 0, 0, 1, 1));
    waitIrq(1, n); waitIrq(1, n);
    chk(pinOut == held, "R9 pin held", pinOut, held);

    // R4: fallback while a timer toggles
    wr(5, 0);
    setTimer(0, 1, 2);
    wr(0, modeByte(0, 1, 1, 0, 0));
    cnt = 0;
    for (int k = 0; k < 12; k++) begin @(posedge clk); #1; if (pinOut) cnt++; end
    chk(cnt == 0, "R4 fallback while running", cnt, 0);

    // R10: select swap keeps toggle value
    setTimer(0, 1, 4);
    wr(0, modeByte(1, 1, 1, 0, 0));
    waitIrq(0, n);
    chk(pinOut == 1'b0, "R10 pre toggle", pinOut, 0);
    wr(0, modeByte(1, 0, 0, 0, 0));
    wr(0, modeByte(2, 0, 0, 0, 0));
    chk(pinOut == 1'b0, "R10 swap hold", pinOut, 0);
    wr(0, modeByte(2, 0, 0, 1, 0));
    chk(pinOut == 1'b1, "R5 preset T1", pinOut, 1);

    finishRun();
  end
endmodule